// File: doc/BRIEF.md
# Dual Parallel Port with Edge Interrupts

This block is a bus-attached port with two 8-bit sides, A and B. Each side has an output latch, a direction mask and a small control register. A CPU reaches all of them through four byte-wide offsets on a simple synchronous bus: chip select, write strobe, a 2-bit offset, and separate write and read data. Each side's data offset leads either to the direction mask or to the pins, and a control bit chooses which.

Each side watches one control input line for a programmable edge. A detected edge is latched as a read-only flag, and an enabled flag pulls a shared active-low interrupt request. Reading the side's pins through the data offset clears the flag. A second control line on each side is driven at a fixed level chosen by a 3-bit control field.

Top module: `dual_pport`

## Requirements
- R1: After reset every register is zero. Both direction masks are zero, so all pins are inputs. The interrupt request is high, both control-line output enables are low, and a read of offset 1 or offset 3 returns 0x00.
- R2: Offset 0 reaches side A's data or direction register and offset 1 reaches side A's control register. Offset 2 reaches side B's data or direction register and offset 3 reaches side B's control register. Writes take effect at the clock edge where chip select and the write strobe are high.
- R3: Control bit 2 of a side selects what its even offset reaches. With 0, reads and writes go to the direction mask. With 1, they go to the output latch and the pins.
- R4: A direction bit of 1 makes that pin an output: the side's output-enable equals its direction mask and its output equals its output latch. Writing 0xFF to the mask makes every pin of the side an output.
- R5: With control bit 2 set, a read of the even offset returns the output latch for output pins and the external pin level for input pins.
- R6: Control bit 1 selects the active edge of a side's first control input: 1 is low-to-high and 0 is high-to-low. A detected edge sets the side's flag, visible as control bit 7 after the clock edge that samples the change, whether or not interrupts are enabled.
- R7: The interrupt request output is low exactly when some side has both its flag and its control bit 0 set.
- R8: A read of a side's even offset with control bit 2 set clears that side's flag after that clock edge. A read with control bit 2 clear leaves the flag set.
- R9: A control read returns the flag in bit 7, zero in bit 6 and the last written bits 5..0. Writes to bits 7 and 6 have no effect.
- R10: The second control line is enabled as an output when control bits 5..4 are 11. Bits 5..3 = 110 drive it high and 111 drive it low. Any other value disables the output and drives level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe (1 write, 0 read) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when not reading) |
| pa_in | input | 8 | Side A pin levels |
| pa_out | output | 8 | Side A output latch |
| pa_oe | output | 8 | Side A output enables |
| ca1 | input | 1 | Side A edge-sensing input |
| ca2 | output | 1 | Side A programmed control level |
| ca2_oe | output | 1 | Side A control-line output enable |
| pb_in | input | 8 | Side B pin levels |
| pb_out | output | 8 | Side B output latch |
| pb_oe | output | 8 | Side B output enables |
| cb1 | input | 1 | Side B edge-sensing input |
| cb2 | output | 1 | Side B programmed control level |
| cb2_oe | output | 1 | Side B control-line output enable |
| irq_n | output | 1 | Active-low combined interrupt request |

## Verification
Random sequences mix control writes, data and direction writes, pin changes, edge toggles and reads on both sides. Mixed direction masks with random pin values separate the latch path from the pin path on each bit. Because random control values switch the even offset between its two targets, a swapped select or a crossed side shows up as a data mismatch. Directed cases set a flag with interrupts disabled to separate flag capture from request gating. They try a control write to bit 7 against the read-only flag, try a direction read that must leave the flag set, and step through the control-line codes 110, 111 and 010.

// File: rtl/dual_pport.sv
module dual_pport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic         ca1,
  output logic         ca2,
  output logic         ca2_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic         cb1,
  output logic         cb2,
  output logic         cb2_oe,
  output logic         irq_n
);
  localparam int PAD = W - 7;

  logic [W-1:0] dat [2];
  logic [W-1:0] ddr [2];
  logic [W-1:0] pin [2];
  logic [W-1:0] view [2];
  logic [5:0]   ctl [2];
  logic [1:0]   flg, c1q, c1, edg, clr, hit;
  logic         side, wr, rd;

  assign side = addr[1];
  assign wr   = cs & we;
  assign rd   = cs & ~we;
  assign pin[0] = pa_in;
  assign pin[1] = pb_in;
  assign c1 = {cb1, ca1};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      view[i] = (ddr[i] & dat[i]) | (~ddr[i] & pin[i]);
      edg[i]  = ctl[i][1] ? (c1[i] & ~c1q[i]) : (~c1[i] & c1q[i]);
      hit[i]  = (side == i[0]);
      clr[i]  = rd & hit[i] & ~addr[0] & ctl[i][2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        dat[i] <= '0;
        ddr[i] <= '0;
        ctl[i] <= '0;
      end
      flg <= '0;
      c1q <= '0;
    end else begin
      c1q <= c1;
      for (int i = 0; i < 2; i++) begin
        if (wr && hit[i]) begin
          if (addr[0])        ctl[i] <= wdata[5:0];
          else if (ctl[i][2]) dat[i] <= wdata;
          else                ddr[i] <= wdata;
        end
        if (edg[i])      flg[i] <= 1'b1;
        else if (clr[i]) flg[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr[0])          rdata = {flg[side], {PAD{1'b0}}, ctl[side]};
      else if (ctl[side][2]) rdata = view[side];
      else                  rdata = ddr[side];
    end
  end

  assign pa_out = dat[0];
  assign pa_oe  = ddr[0];
  assign pb_out = dat[1];
  assign pb_oe  = ddr[1];
  assign ca2_oe = ctl[0][5] & ctl[0][4];
  assign ca2    = (ctl[0][5:3] == 3'b110);
  assign cb2_oe = ctl[1][5] & ctl[1][4];
  assign cb2    = (ctl[1][5:3] == 3'b110);
  assign irq_n  = ~|(flg & {ctl[1][0], ctl[0][0]});

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd0 && ctl[0][2] && !edg[0]) |=> !flg[0]);
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[1][1] && !c1q[1] && cb1) |=> flg[1]);
  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && !ctl[0][2]) |=> (pa_oe == $past(wdata)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pa_oe) && $stable(pb_out) && $stable(ca2_oe)));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0][0] && ctl[0][1] && !c1q[0] && ca1) |=> !irq_n);
endmodule

// File: tb/dual_pport_test.sv
module dual_pport_test;
  logic clk = 0, rst_n = 0, cs = 0, we = 0, ca1 = 0, cb1 = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic ca2, ca2_oe, cb2, cb2_oe, irq_n;
  int checks = 0, errors = 0;
  logic [7:0] m_dat [2], m_ddr [2];
  logic [5:0] m_ctl [2];
  logic m_flg [2], m_c1 [2];
  int seed = 7;

  always #4 clk = ~clk;

  dual_pport uut (.clk, .rst_n, .cs, .we, .addr, .wdata, .rdata,
    .pa_in, .pa_out, .pa_oe, .ca1, .ca2, .ca2_oe,
    .pb_in, .pb_out, .pb_oe, .cb1, .cb2, .cb2_oe, .irq_n);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pins(int s);
    return s ? pb_in : pa_in;
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    int s = a[1];
    if (a[0]) return {m_flg[s], 1'b0, m_ctl[s]};
    if (m_ctl[s][2]) return (m_ddr[s] & m_dat[s]) | (~m_ddr[s] & pins(s));
    return m_ddr[s];
  endfunction

  task automatic outs(string tag);
    logic [2:0] fa = m_ctl[0][5:3], fb = m_ctl[1][5:3];
    chk({tag, " R4 pa_oe"}, pa_oe, m_ddr[0]);
    chk({tag, " R4 pa_out"}, pa_out, m_dat[0]);
    chk({tag, " R4 pb_oe"}, pb_oe, m_ddr[1]);
    chk({tag, " R4 pb_out"}, pb_out, m_dat[1]);
    chk({tag, " R7 irq_n"}, irq_n,
        !((m_flg[0] && m_ctl[0][0]) || (m_flg[1] && m_ctl[1][0])));
    chk({tag, " R10 ca2"}, {ca2_oe, ca2}, {fa[2:1] == 2'b11, fa == 3'b110});
    chk({tag, " R10 cb2"}, {cb2_oe, cb2}, {fb[2:1] == 2'b11, fb == 3'b110});
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    int s = a[1];
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; we = 0;
    if (a[0]) m_ctl[s] = d[5:0];
    else if (m_ctl[s][2]) m_dat[s] = d;
    else m_ddr[s] = d;
    #1 outs("wr");
  endtask

  task automatic rd(logic [1:0] a, string tag);
    int s = a[1];
    @(negedge clk); cs = 1; we = 0; addr = a;
    #1 chk({tag, " read"}, rdata, exp_rd(a));
    @(posedge clk); #1 cs = 0;
    if (!a[0] && m_ctl[s][2]) m_flg[s] = 0;
    #1 outs(tag);
  endtask

  task automatic tog(int s);
    logic nl = ~m_c1[s];
    @(negedge clk);
    if (s) cb1 = nl; else ca1 = nl;
    @(posedge clk); #1;
    m_c1[s] = nl;
    if (m_ctl[s][1] == nl) m_flg[s] = 1;
    #1 outs("R6 edge");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_dat[i] = 0; m_ddr[i] = 0; m_ctl[i] = 0; m_flg[i] = 0; m_c1[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 outs("R1 reset");
    rd(2'd1, "R1 ctlA");
    rd(2'd3, "R1 ctlB");
    rd(2'd0, "R1 dirA");

    // R3 R4: direction then latch
    wr(2'd0, 8'hFF);
    wr(2'd1, 6'h04);
    wr(2'd0, 8'hA5);
    pa_in = 8'h3C;
    rd(2'd0, "R5 all out");
    wr(2'd1, 6'h00);
    wr(2'd0, 8'h0F);
    wr(2'd1, 6'h04);
    rd(2'd0, "R5 mixed");
    // R6: flag with irq disabled (falling edge selected)
    tog(0); tog(0);
    rd(2'd1, "R6 flag disabled");
    wr(2'd1, 6'h05);
    rd(2'd1, "R7 enabled");
    // R9: bit 7 write ignored
    wr(2'd1, 8'h85);
    rd(2'd1, "R9 ro flag");
    // R8: direction read keeps flag, data read clears it
    wr(2'd1, 6'h01);
    rd(2'd0, "R8 dir read");
    rd(2'd1, "R8 still set");
    wr(2'd1, 6'h05);
    rd(2'd0, "R8 data read");
    rd(2'd1, "R8 cleared");
    // R10 codes
    wr(2'd3, 6'h30);
    wr(2'd3, 6'h38);
    wr(2'd3, 6'h10);
    // B rising edge with irq
    wr(2'd3, 6'h07);
    tog(1);
    rd(2'd3, "R6 B rise");
    rd(2'd2, "R8 B clear");

    for (int n = 0; n < 600; n++) begin
      int op = $urandom(seed) % 5;
      seed = seed + 1;
      case (op)
        0: wr({1'($urandom % 2), 1'b1}, 8'($urandom));
        1: wr({1'($urandom % 2), 1'b0}, 8'($urandom));
        2: rd(2'($urandom), "R2 rand");
        3: begin
          @(negedge clk); pa_in = 8'($urandom); pb_in = 8'($urandom);
          #1 outs("R5 pins");
        end
        default: tog($urandom % 2);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule